// File: doc/BRIEF.md
# ADC Channel and Reference Selection Shadow Register

This block holds the input-channel and voltage-reference choice for a successive-approximation converter. Software writes a selection byte into a holding copy. The block moves that copy into an active selection only at safe points, so a change never disturbs a conversion that is already running. The active selection drives the analog input multiplexer and the reference switch. The block decodes the channel field into one select line for each source.

The converter reports four things to the block: its enable, its auto-trigger mode, a strobe on the ADC clock edge where a conversion begins, and a strobe when a conversion completes. The active selection moves in these cases:
- on each enabled conversion start;
- whenever the converter is enabled, idle and not in auto-trigger mode;
- on the edge where the enable rises.

While the enable is low, or while a conversion is running, the active selection stays fixed. In auto-trigger mode with no conversion running, a new selection waits for the next trigger. It is also applied if auto-trigger is switched off. A CPU read returns the holding copy.

Top module: `adcsel_shadow`

## Requirements
- R1: The selection byte carries the channel code in bits 3:0 and the reference select in bit 4, where 1 means the internal 1.1 V reference and 0 means the analog supply. A CPU read returns the holding copy in those bits with bits 7:5 at zero, and shows a write from the cycle after that write.
- R2: Reset clears the holding copy and the active selection to zero. After reset, external pin 0 is routed, the only line set is bit 0 of `pin_sel`, and the reference select is 0.
- R3: While `adc_en` is low, the active selection does not change, and `conv_start` is ignored: it loads nothing and does not begin a conversion.
- R4: While `adc_en` is high, `auto_en` is low and no conversion is running, the active selection takes the holding copy on the next clock edge.
- R5: An enabled `conv_start` copies into the active selection the holding value present before that edge. A write in the same cycle as the start applies only to a later conversion.
- R6: A conversion runs from an enabled `conv_start` until `conv_done` is seen or `adc_en` goes low. While it runs, the active selection does not change, whatever is written.
- R7: In auto-trigger mode with no conversion running, the active selection keeps its value until the next trigger. Clearing `auto_en` while idle and enabled applies the holding copy on the next edge.
- R8: On the edge where `adc_en` goes from low to high, the active selection takes the holding copy in either mode.
- R9: Channel codes 0 to 7 set the matching bit of `pin_sel`. Code 8 sets `temp_sel`, code 14 sets `bandgap_sel`, and codes 9 to 13 and 15 set `gnd_sel`. Exactly one of these lines is high at any time.
- R10: When `conv_start` and `conv_done` arrive in the same cycle, the new conversion begins: the holding copy is loaded, and the conversion counts as running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe for the selection byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Holding copy read back |
| adc_en | input | 1 | Converter enable |
| auto_en | input | 1 | Auto-trigger mode |
| conv_start | input | 1 | Strobe on the edge where a conversion begins |
| conv_done | input | 1 | Strobe when a conversion completes |
| act_chan | output | 4 | Active channel code |
| act_vref | output | 1 | Active reference select |
| pin_sel | output | 8 | One-hot select of external pins |
| temp_sel | output | 1 | Temperature sensor selected |
| bandgap_sel | output | 1 | Bandgap selected |
| gnd_sel | output | 1 | Ground selected |

## Verification
The bench writes a selection in the same cycle as a start. A design that took the fresh value would switch the channel of a conversion that is already under way. It writes during a conversion and while the converter is disabled, to catch early transfer. It also holds the block idle in auto-trigger mode, where a design that tracked the holding copy would move the mux before the trigger. Back-to-back done and start, the enable rising in auto mode, and a full sweep of all sixteen codes check that busy is not dropped, that the enable edge is not missed, and that unused codes are not routed to a pin or the sensor.

// File: rtl/adcsel_pkg.sv
package adcsel_pkg;
    localparam int DATA_W   = 8;
    localparam int CHAN_W   = 4;
    localparam int NUM_PINS = 8;
    localparam int REF_POS  = 4;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              vref;
    } sel_t;

    typedef struct packed {
        logic [NUM_PINS-1:0] pins;
        logic                temp;
        logic                bg;
        logic                gnd;
    } route_t;

    function automatic route_t route_of(sel_t s, int temp_code, int bg_code);
        route_t r;
        r      = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            r.pins[i] = (32'(s.chan) == i);
        end
        r.temp = (32'(s.chan) == temp_code);
        r.bg   = (32'(s.chan) == bg_code);
        r.gnd  = ~(|r.pins) & ~r.temp & ~r.bg;
        return r;
    endfunction
endpackage

// File: rtl/adcsel_hold.sv
module adcsel_hold
    import adcsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output sel_t              hold_sel,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        sel_t sel;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel.chan = wdata[CHAN_W-1:0];
            st_d.sel.vref = wdata[REF_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_sel = st_q.sel;

    always_comb begin
        rdata               = '0;
        rdata[CHAN_W-1:0]   = st_q.sel.chan;
        rdata[REF_POS]      = st_q.sel.vref;
    end
endmodule

// File: rtl/adcsel_ctrl.sv
module adcsel_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_en,
    input  logic auto_en,
    input  logic conv_start,
    input  logic conv_done,
    output logic load,
    output logic busy
);
    typedef struct packed {
        logic busy;
        logic en_prev;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     start_ok;
    logic     idle_track;
    logic     en_rise;

    always_comb begin
        start_ok   = conv_start & adc_en;
        idle_track = adc_en & ~st_q.busy & ~auto_en;
        en_rise    = adc_en & ~st_q.en_prev;
        load       = start_ok | idle_track | en_rise;

        st_d         = st_q;
        st_d.en_prev = adc_en;
        if (!adc_en)        st_d.busy = 1'b0;
        else if (start_ok)  st_d.busy = 1'b1;
        else if (conv_done) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/adcsel_active.sv
module adcsel_active
    import adcsel_pkg::*;
#(
    parameter int TEMP_CODE = 8,
    parameter int BG_CODE   = 14
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  sel_t   hold_sel,
    output sel_t   act_sel,
    output route_t route
);
    typedef struct packed {
        sel_t   sel;
        route_t rt;
    } act_st_t;

    localparam sel_t   RST_SEL = '0;
    localparam route_t RST_RT  = route_of(RST_SEL, TEMP_CODE, BG_CODE);

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sel = hold_sel;
            st_d.rt  = route_of(hold_sel, TEMP_CODE, BG_CODE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= RST_SEL;
            st_q.rt  <= RST_RT;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_sel = st_q.sel;
    assign route   = st_q.rt;
endmodule

// File: rtl/adcsel_shadow.sv
module adcsel_shadow
    import adcsel_pkg::*;
#(
    parameter int TEMP_CODE = 8,
    parameter int BG_CODE   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                adc_en,
    input  logic                auto_en,
    input  logic                conv_start,
    input  logic                conv_done,
    output logic [CHAN_W-1:0]   act_chan,
    output logic                act_vref,
    output logic [NUM_PINS-1:0] pin_sel,
    output logic                temp_sel,
    output logic                bandgap_sel,
    output logic                gnd_sel
);
    sel_t   hold_sel;
    sel_t   act_sel;
    route_t route;
    logic   load;
    logic   busy;

    adcsel_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr),
        .wdata    (cpu_wdata),
        .hold_sel (hold_sel),
        .rdata    (cpu_rdata)
    );

    adcsel_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_en     (adc_en),
        .auto_en    (auto_en),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .load       (load),
        .busy       (busy)
    );

    adcsel_active #(
        .TEMP_CODE (TEMP_CODE),
        .BG_CODE   (BG_CODE)
    ) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .hold_sel (hold_sel),
        .act_sel  (act_sel),
        .route    (route)
    );

    assign act_chan    = act_sel.chan;
    assign act_vref    = act_sel.vref;
    assign pin_sel     = route.pins;
    assign temp_sel    = route.temp;
    assign bandgap_sel = route.bg;
    assign gnd_sel     = route.gnd;
endmodule

// File: rtl/adcsel_checker.sv
module adcsel_checker
    import adcsel_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                adc_en,
    input logic                conv_start,
    input logic                cpu_wr,
    input logic [DATA_W-1:0]   cpu_wdata,
    input logic [DATA_W-1:0]   cpu_rdata,
    input logic                busy,
    input sel_t                hold_sel,
    input logic [CHAN_W-1:0]   act_chan,
    input logic                act_vref,
    input logic [NUM_PINS-1:0] pin_sel,
    input logic                temp_sel,
    input logic                bandgap_sel,
    input logic                gnd_sel
);
    // R3
    a_r3_frozen_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> $stable({act_chan, act_vref}));

    // R6
    a_r6_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adc_en && !conv_start) |=> $stable({act_chan, act_vref}));

    // R5
    a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && adc_en) |=> ({act_chan, act_vref} == $past({hold_sel.chan, hold_sel.vref})));

    // R9
    a_r9_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pin_sel, temp_sel, bandgap_sel, gnd_sel}) == 1);

    // R1
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (cpu_rdata[CHAN_W-1:0] == $past(cpu_wdata[CHAN_W-1:0])
                    && cpu_rdata[REF_POS] == $past(cpu_wdata[REF_POS])));
endmodule

bind adcsel_shadow adcsel_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_en      (adc_en),
    .conv_start  (conv_start),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .busy        (busy),
    .hold_sel    (hold_sel),
    .act_chan    (act_chan),
    .act_vref    (act_vref),
    .pin_sel     (pin_sel),
    .temp_sel    (temp_sel),
    .bandgap_sel (bandgap_sel),
    .gnd_sel     (gnd_sel)
);

// File: tb/tb_adcsel_shadow.sv
module tb_adcsel_shadow;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       adc_en = 1'b0, auto_en = 1'b0, conv_start = 1'b0, conv_done = 1'b0;
    logic [3:0] act_chan;
    logic       act_vref;
    logic [7:0] pin_sel;
    logic       temp_sel, bandgap_sel, gnd_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adcsel_shadow dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .adc_en(adc_en), .auto_en(auto_en),
        .conv_start(conv_start), .conv_done(conv_done), .act_chan(act_chan),
        .act_vref(act_vref), .pin_sel(pin_sel), .temp_sel(temp_sel),
        .bandgap_sel(bandgap_sel), .gnd_sel(gnd_sel)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       en;
        logic       au;
        logic       st;
        logic       dn;
        logic [3:0] ech;
        logic       eref;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R3 write while disabled
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R3
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  1'b1}, // R8/R4 enable applies
        '{1'b1, 8'h05, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3,  1'b1}, // R5 same-cycle write
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  1'b1}, // R6 busy
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3,  1'b1}, // R6 done edge
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5,  1'b0}, // R4 idle track
        '{1'b1, 8'h08, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5,  1'b0}, // R7 auto idle waits
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8,  1'b0}, // R5 trigger loads
        '{1'b1, 8'h1E, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b0}, // R6
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 4'd14, 1'b1}, // R10 back to back
        '{1'b1, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, 4'd14, 1'b1}, // R10 still busy
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 4'd14, 1'b1}, // R6
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 4'd14, 1'b1}, // R7 auto idle holds
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2,  1'b0}, // R7 auto cleared
        '{1'b1, 8'h17, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2,  1'b0}, // R3 start ignored
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2,  1'b0}, // R3
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7,  1'b1}, // R8 rise in auto
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7,  1'b1}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7,  1'b1}  // R3 disable ends busy
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cpu_wr = 0; cpu_wdata = '0; conv_start = 0; conv_done = 0;
    endtask

    function automatic logic [10:0] exp_route(input int c);
        logic [10:0] r;
        r = '0;
        if (c < 8)       r[10:3] = 8'(1 << c);
        else if (c == 8)  r[2] = 1'b1;
        else if (c == 14) r[1] = 1'b1;
        else              r[0] = 1'b1;
        return r;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(); step();
        // R2 reset state
        chk("R2 chan", 32'(act_chan), 0);
        chk("R2 vref", 32'(act_vref), 0);
        chk("R2 route", 32'({pin_sel, temp_sel, bandgap_sel, gnd_sel}), 32'(exp_route(0)));
        chk("R2 rdata", 32'(cpu_rdata), 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NV; i++) begin
            cpu_wr = VECS[i].wr; cpu_wdata = VECS[i].wd;
            adc_en = VECS[i].en; auto_en = VECS[i].au;
            conv_start = VECS[i].st; conv_done = VECS[i].dn;
            step();
            chk($sformatf("vec%0d chan (R3-R10 table)", i), 32'(act_chan), 32'(VECS[i].ech));
            chk($sformatf("vec%0d vref", i), 32'(act_vref), 32'(VECS[i].eref));
        end
        idle_inputs();

        // R1 readback with unused bits zero
        cpu_wr = 1; cpu_wdata = 8'hFF; step(); idle_inputs();
        chk("R1 rdata masked", 32'(cpu_rdata), 32'h1F);
        cpu_wr = 1; cpu_wdata = 8'hA6; step(); idle_inputs();
        chk("R1 rdata", 32'(cpu_rdata), 32'h06);

        // R9 decode sweep in enabled single idle mode (R4 transfer)
        adc_en = 1; auto_en = 0;
        for (int c = 0; c < 16; c++) begin
            cpu_wr = 1; cpu_wdata = 8'(c) | 8'h10; step(); idle_inputs();
            step();
            chk($sformatf("R9 code %0d route", c),
                32'({pin_sel, temp_sel, bandgap_sel, gnd_sel}), 32'(exp_route(c)));
            chk($sformatf("R4 code %0d chan", c), 32'(act_chan), c);
        end

        // R2 reset in the middle of a conversion
        conv_start = 1; step(); idle_inputs();
        rst_n = 0; #1;
        chk("R2 async chan", 32'(act_chan), 0);
        chk("R2 async rdata", 32'(cpu_rdata), 0);
        chk("R2 async route", 32'({pin_sel, temp_sel, bandgap_sel, gnd_sel}), 32'(exp_route(0)));
        step();
        rst_n = 1;
        step();
        finish_run();
    end
endmodule